// File: doc/BRIEF.md
# Deferred Counter Increment Queue

This block keeps a small bank of counters together with a queue of additions that wait before they are applied. A client posts a request that names a counter, gives a signed amount and gives a wait in cycles. The block records an absolute due cycle for the request, formed from its own free-running cycle count plus the wait. On every cycle it scans all held requests. Each request whose due cycle has arrived is folded into its counter in a single update, and its slot is released in that same cycle.

Requests do not leave in the order they were posted; each one leaves when its own due cycle comes. When several requests fall due together, the scan handles all of them in one cycle. Requests aimed at the same counter are added together, so no contribution is lost. The counter bank and the cycle count are outputs that can be read at any time.

Top module: `deferred_bump_queue`

## Requirements
- R1: In reset, and in the first cycle after reset, every counter reads zero, the cycle count reads zero, no request is held and `post_ready` is high.
- R2: `now_cycle` goes up by one on each clock edge after reset and wraps at 2^TW.
- R3: A request accepted in cycle T with a wait of d ≥ 1 is added at the edge that ends cycle T+d. Its counter shows the new value from cycle T+d+1.
- R4: A request with a wait of zero is treated like a wait of one: it is added at the edge that ends cycle T+1.
- R5: `post_amt` is a two's-complement signed value that is sign-extended to CW bits. Counters wrap modulo 2^CW.
- R6: When several held requests fall due in the same cycle and name the same counter, every one of their amounts goes into that counter at the same edge.
- R7: Requests retire by due cycle, not by posting order. A later post with a shorter wait is added before an earlier post with a longer wait.
- R8: The queue holds DEPTH (default 8) requests. With all slots held and none due, `post_ready` is low and a request offered then is dropped and has no effect on any counter.
- R9: With all slots held, `post_ready` is high in any cycle in which at least one held request is due. A request offered in that cycle is accepted into the slot being freed.
- R10: An added request changes only the counter at index `post_ctr`. Counters that no due request names keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| post_valid | input | 1 | A request is offered this cycle |
| post_ready | output | 1 | The queue can take a request this cycle |
| post_ctr | input | IW | Index of the target counter |
| post_amt | input | AW | Signed amount to add |
| post_delay | input | DW | Wait in cycles before the add |
| now_cycle | output | TW | Free-running cycle count |
| ctr_bank | output | NCTR×CW | Current value of each counter, packed with counter 0 in the low bits |

## Verification
The hardest situation to reach is a full queue in which a request is offered exactly in the cycle that a slot retires. To reach it, the bench fills all eight slots with long waits and then keeps a request on the post port every cycle. Early offers must be refused, and the offer in the first due cycle must take the freed slot. A second hard case is several requests hitting one counter in the same cycle. The bench builds it by posting to one counter on consecutive cycles with waits that shrink by one, so all of them share a single due cycle. A long pseudo-random sweep then mixes waits, amounts and targets against a cycle-accurate model kept in the bench.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int DQ_DEPTH = 8;
  localparam int DQ_NCTR  = 4;
  localparam int DQ_CW    = 16;
  localparam int DQ_AW    = 8;
  localparam int DQ_DW    = 8;
  localparam int DQ_TW    = 16;

  // True when 'now' has reached or passed 'due' on a tw-bit wrapping scale.
  function automatic logic due_reached(input logic [31:0] now, input logic [31:0] due,
                                       input int tw);
    logic [31:0] diff;
    diff = now - due;
    return diff[tw-1] == 1'b0;
  endfunction
endpackage

// File: rtl/dq_pick.sv
module dq_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;

  always_comb begin
    if (any) begin
      gnt_onehot_chk: assert ($countones(gnt) == 1);
    end
  end
endmodule

// File: rtl/dq_sum.sv
module dq_sum #(
  parameter int DEPTH = 8,
  parameter int NCTR  = 4,
  parameter int IW    = 2,
  parameter int AW    = 8,
  parameter int CW    = 16
) (
  input  logic [DEPTH-1:0]         fire,
  input  logic [DEPTH-1:0][IW-1:0] idx,
  input  logic [DEPTH-1:0][AW-1:0] amt,
  output logic [NCTR-1:0][CW-1:0]  delta
);
  function automatic logic [CW-1:0] widen(input logic [AW-1:0] a);
    return CW'($signed(a));
  endfunction

  always_comb begin
    for (int c = 0; c < NCTR; c++) begin
      delta[c] = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (fire[e] && int'(idx[e]) == c) delta[c] = delta[c] + widen(amt[e]);
      end
    end
  end
endmodule

// File: rtl/deferred_bump_queue.sv
module deferred_bump_queue #(
  parameter int DEPTH = dq_pkg::DQ_DEPTH,
  parameter int NCTR  = dq_pkg::DQ_NCTR,
  parameter int CW    = dq_pkg::DQ_CW,
  parameter int AW    = dq_pkg::DQ_AW,
  parameter int DW    = dq_pkg::DQ_DW,
  parameter int TW    = dq_pkg::DQ_TW,
  localparam int IW   = (NCTR > 1) ? $clog2(NCTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     post_valid,
  output logic                     post_ready,
  input  logic [IW-1:0]            post_ctr,
  input  logic [AW-1:0]            post_amt,
  input  logic [DW-1:0]            post_delay,
  output logic [TW-1:0]            now_cycle,
  output logic [NCTR-1:0][CW-1:0]  ctr_bank
);
  logic [TW-1:0]            now_q;
  logic [DEPTH-1:0]         slot_v;
  logic [DEPTH-1:0][IW-1:0] slot_ctr;
  logic [DEPTH-1:0][AW-1:0] slot_amt;
  logic [DEPTH-1:0][TW-1:0] slot_due;
  logic [NCTR-1:0][CW-1:0]  ctr_q;
  logic [NCTR-1:0][CW-1:0]  ctr_delta;

  // Named events for the checks
  logic [DEPTH-1:0] retire_vec;
  logic [DEPTH-1:0] avail_vec;
  logic [DEPTH-1:0] alloc_oh;
  logic             post_fire;
  logic [TW-1:0]    due_new;

  for (genvar g = 0; g < DEPTH; g++) begin : g_scan
    assign retire_vec[g] = slot_v[g] &&
                           dq_pkg::due_reached(32'(now_q), 32'(slot_due[g]), TW);
  end

  assign avail_vec = ~slot_v | retire_vec;
  assign post_fire = post_valid & post_ready;
  assign due_new   = now_q + TW'(post_delay);

  dq_pick #(.N(DEPTH)) u_pick (
    .req (avail_vec),
    .gnt (alloc_oh),
    .any (post_ready)
  );

  dq_sum #(.DEPTH(DEPTH), .NCTR(NCTR), .IW(IW), .AW(AW), .CW(CW)) u_sum (
    .fire  (retire_vec),
    .idx   (slot_ctr),
    .amt   (slot_amt),
    .delta (ctr_delta)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v   <= '0;
      slot_ctr <= '0;
      slot_amt <= '0;
      slot_due <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (post_fire && alloc_oh[i]) begin
          slot_v[i]   <= 1'b1;
          slot_ctr[i] <= post_ctr;
          slot_amt[i] <= post_amt;
          slot_due[i] <= due_new;
        end else if (retire_vec[i]) begin
          slot_v[i]   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_q <= '0;
    else begin
      for (int c = 0; c < NCTR; c++) ctr_q[c] <= ctr_q[c] + ctr_delta[c];
    end
  end

  assign now_cycle = now_q;
  assign ctr_bank  = ctr_q;

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now_q == $past(now_q) + 1'b1);

  // R10
  ctr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(ctr_q) |-> $past(|retire_vec));

  // R3
  retire_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (slot_v & $past(retire_vec & ~(alloc_oh & {DEPTH{post_fire}}))) == '0);

  // R8
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(&slot_v) && $past(retire_vec) == '0 |-> $stable(slot_v));

  // R9
  post_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> (slot_v & $past(alloc_oh)) == $past(alloc_oh));
endmodule

// File: tb/test_deferred_bump_queue.sv
module test_deferred_bump_queue;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             post_valid = 1'b0;
  logic             post_ready;
  logic [1:0]       post_ctr = '0;
  logic [7:0]       post_amt = '0;
  logic [7:0]       post_delay = '0;
  logic [15:0]      now_cycle;
  logic [3:0][15:0] ctr_bank;

  int checks = 0;
  int errors = 0;

  // Model state
  bit          m_v[8];
  int          m_idx[8];
  int          m_amt[8];
  int          m_due[8];
  logic [15:0] m_ctr[4];
  int          m_now = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deferred_bump_queue i_deferred_bump_queue (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_ready(post_ready),
    .post_ctr(post_ctr), .post_amt(post_amt), .post_delay(post_delay),
    .now_cycle(now_cycle), .ctr_bank(ctr_bank)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int c = 0; c < 4; c++)
      check(ctr_bank[c] == m_ctr[c], tag, $sformatf("counter %0d", c),
            int'(ctr_bank[c]), int'(m_ctr[c]));
  endtask

  // One cycle: drive after the falling edge, model the rising edge, check at the next falling edge.
  task automatic step(input bit v, input int ctr, input int amt, input int dly, input string tag);
    int  cnt;
    bit  anydue;
    bit  exp_rdy;
    bit  placed;
    post_valid = v;
    post_ctr   = 2'(ctr);
    post_amt   = 8'(amt);
    post_delay = 8'(dly);
    cnt = 0;
    anydue = 0;
    for (int m = 0; m < 8; m++) if (m_v[m]) begin
      cnt++;
      if (m_due[m] <= m_now) anydue = 1;
    end
    exp_rdy = (cnt < 8) || anydue;
    #1;
    check(post_ready == exp_rdy, tag, "post_ready", int'(post_ready), int'(exp_rdy));
    @(posedge clk);
    for (int m = 0; m < 8; m++) if (m_v[m] && m_due[m] <= m_now) begin
      m_ctr[m_idx[m]] = m_ctr[m_idx[m]] + 16'(m_amt[m]);
      m_v[m] = 0;
    end
    if (v && exp_rdy) begin
      placed = 0;
      for (int m = 0; m < 8; m++) if (!m_v[m] && !placed) begin
        m_v[m] = 1; m_idx[m] = ctr; m_amt[m] = amt; m_due[m] = m_now + dly;
        placed = 1;
      end
    end
    m_now++;
    @(negedge clk);
    post_valid = 1'b0;
    check(now_cycle == 16'(m_now), "R2", "now_cycle", int'(now_cycle), m_now);
    check_bank(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int m = 0; m < 8; m++) m_v[m] = 0;
    for (int c = 0; c < 4; c++) m_ctr[c] = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(post_ready == 1'b1, "R1", "post_ready", int'(post_ready), 1);
    check(now_cycle == 16'd0, "R1", "now_cycle", int'(now_cycle), 0);
    check_bank("R1");
    rst_n = 1'b1;
    #1;
    check(post_ready == 1'b1, "R1", "post_ready after release", int'(post_ready), 1);

    // R3: plain wait
    step(1, 1, 5, 3, "R3");
    idle(6, "R3");
    // R4: zero wait
    step(1, 2, 7, 0, "R4");
    idle(3, "R4");
    // R5: negative amounts and wrap
    step(1, 0, -1, 1, "R5");
    idle(3, "R5");
    step(1, 0, -128, 2, "R5");
    step(1, 0, 127, 0, "R5");
    idle(4, "R5");
    // R6: three requests on one counter sharing one due cycle
    step(1, 3, 10, 4, "R6");
    step(1, 3, 20, 3, "R6");
    step(1, 3, -5, 2, "R6");
    idle(5, "R6");
    // R7: out-of-order retirement
    step(1, 1, 3, 9, "R7");
    step(1, 1, 4, 1, "R7");
    idle(10, "R7");
    // R10: only the named counter moves
    step(1, 2, 9, 1, "R10");
    idle(3, "R10");
    // R8: fill all slots, offers are refused
    for (int k = 0; k < 8; k++) step(1, 0, k + 1, 40, "R8");
    for (int k = 0; k < 3; k++) step(1, 1, 50, 0, "R8");
    // R9: keep offering until a slot frees in the due cycle
    for (int k = 0; k < 45; k++) step(1, 1, 1, 5, "R9");
    idle(60, "R9");
    // Sweep: mixed waits, amounts and targets
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], int'(lfsr[3:2]), int'($signed(lfsr[15:8])),
           int'(lfsr[7:4]), "R7");
    end
    idle(20, "R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule